// File: doc/BRIEF.md
# Tagged Multi-Size Translation Cache

This block holds recently used virtual-to-physical page mappings for a 48-bit virtual address space. A requester presents a virtual address, an address-space tag and an access kind. In the same cycle the block answers with a hit flag, the translated physical address, a permission-fault flag, and a request to set the page's dirty bit. Every resident entry is compared against the request at once. An entry only answers a requester whose tag equals its own, so mappings from several address spaces can stay resident side by side. Each entry records its own page size, so 4 KB, 2 MB and 1 GB mappings share the same storage.

After a miss, external walk logic installs the mapping through the fill port. The fill uses a free slot if one exists. When no slot is free, it replaces the entry that was used longest ago. Two invalidation commands exist: one removes every entry carrying a given tag, the other empties the whole buffer. Each clock edge, the write side decodes the fill and invalidate inputs into one of four operations: idle, fill, invalidate-by-tag, or flush. Idle is chosen when no command is raised. Flush is chosen whenever the flush input is high. Invalidate-by-tag is chosen when the tag-invalidate input is high without a flush. Fill is chosen when only the fill input is high. Each operation completes in that single edge, so the decode keeps no state between cycles.

Top module: `vtag_xlat_cache`

## Requirements
- R1: A lookup is combinational. The request is compared against all entries in parallel, and hit, address and flags are valid in the cycle the request is driven.
- R2: On a hit, the physical address is the stored frame number with the low page-offset bits replaced by the same bits of the virtual address. For 4 KB pages these are bits 11:0, for 2 MB pages bits 20:0, and for 1 GB pages bits 29:0.
- R3: An entry only hits when its stored tag equals the request tag.
- R4: An invalid entry never hits. After reset every entry is invalid. A lookup that matches no valid entry gives hit = 0 and a physical address of 0.
- R5: The permission field is bit 0 = read, bit 1 = write, bit 2 = execute. The access code is 0 = read, 1 = write, 2 = execute; code 3 is never permitted. The fault flag is raised only on a hit whose access kind is not permitted.
- R6: The size code sets how many virtual address bits are compared. Code 0 is a 4 KB page and compares bits 47:12. Code 1 is a 2 MB page and compares bits 47:21. Code 2 is a 1 GB page and compares bits 47:30. Code 3 is treated as code 0.
- R7: A fill writes the lowest-numbered invalid entry whenever one exists. It sets the valid bit and stores the page number, frame, tag, size, permissions and dirty bit.
- R8: When every entry is valid, a fill replaces the least recently used entry. Both hits and fills count as uses; misses do not.
- R9: Invalidate-by-tag clears every entry with that tag in one edge and leaves entries with other tags in place. A lookup in the same cycle sees the state from before the invalidate.
- R10: Flush clears every entry in one edge. Priority is flush, then invalidate-by-tag, then fill. A fill raised in the same cycle as either invalidate is dropped.
- R11: The dirty-request output is raised when a write hits an entry that permits writing and whose dirty bit is clear. It is raised at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_tag | input | TAG_W (8) | Lookup address-space tag |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Matching valid entry found |
| lk_paddr | output | PA_W (44) | Translated physical address |
| lk_fault | output | 1 | Hit, but the access kind is not permitted |
| lk_dirty_req | output | 1 | Permitted write to a clean page |
| fill_en | input | 1 | Install an entry at this edge |
| fill_vpn | input | 36 | Virtual page number (address bits 47:12) |
| fill_tag | input | TAG_W (8) | Tag of the new entry |
| fill_pfn | input | PA_W-12 (32) | Frame number in 4 KB units |
| fill_size | input | 2 | Page-size code |
| fill_perm | input | 3 | Permissions {execute, write, read} |
| fill_dirty | input | 1 | Initial dirty bit |
| inv_tag_en | input | 1 | Invalidate all entries with inv_tag |
| inv_tag | input | TAG_W (8) | Tag to invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The checker assumes the environment never fills a mapping that is already resident for the same tag. Under that assumption at most one entry can match a request, and the recency ages stay a permutation. The stimulus only fills after confirming a miss, or after an invalidation has freed the page. It raises fill and invalidate together only where the dropping of the fill is under test. The checker also assumes that the fill, invalidate and flush inputs are held low while reset is asserted. The bench keeps those inputs low throughout reset.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_1G  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSV   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_FILL    = 2'd1,
        OP_INV_TAG = 2'd2,
        OP_INV_ALL = 2'd3
    } op_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    localparam int SHIFT_4K = 12;
    localparam int EXTRA_2M = 9;
    localparam int EXTRA_1G = 18;

endpackage

// File: rtl/xlat_entry_match.sv
module xlat_entry_match
    import xlat_pkg::*;
#(
    parameter int VPN_W = 36,
    parameter int TAG_W = 8
) (
    input  logic             e_valid,
    input  logic [VPN_W-1:0] e_vpn,
    input  logic [TAG_W-1:0] e_tag,
    input  pg_size_e         e_size,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);

    logic [VPN_W-1:0] care;

    always_comb begin
        unique case (e_size)
            PG_2M:   care = {{(VPN_W-EXTRA_2M){1'b1}}, {EXTRA_2M{1'b0}}};
            PG_1G:   care = {{(VPN_W-EXTRA_1G){1'b1}}, {EXTRA_1G{1'b0}}};
            default: care = '1;
        endcase
    end

    assign hit = e_valid && (e_tag == req_tag) && (((e_vpn ^ req_vpn) & care) == '0);

endmodule

// File: rtl/xlat_age_tracker.sv
module xlat_age_tracker #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            touch,
    input  logic [IDX_W-1:0]                touch_idx,
    output logic [ENTRIES-1:0][IDX_W-1:0]   age_q
);

    logic [IDX_W-1:0] ref_age;

    assign ref_age = age_q[touch_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)      age_q[i] <= '0;
                else if (age_q[i] < ref_age)     age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]              valid,
    input  logic [ENTRIES-1:0][IDX_W-1:0]   age,
    output logic [IDX_W-1:0]                victim
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] lru_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age[i] == OLDEST) lru_idx = IDX_W'(i);
        end
    end

    assign victim = free_found ? free_idx : lru_idx;

endmodule

// File: rtl/vtag_xlat_cache.sv
module vtag_xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 8,
    parameter int PA_W    = 44,
    parameter int VA_W    = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [1:0]         lk_acc,
    output logic               lk_hit,
    output logic [PA_W-1:0]    lk_paddr,
    output logic               lk_fault,
    output logic               lk_dirty_req,
    input  logic               fill_en,
    input  logic [VA_W-13:0]   fill_vpn,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [PA_W-13:0]   fill_pfn,
    input  logic [1:0]         fill_size,
    input  logic [2:0]         fill_perm,
    input  logic               fill_dirty,
    input  logic               inv_tag_en,
    input  logic [TAG_W-1:0]   inv_tag,
    input  logic               inv_all
);

    localparam int VPN_W = VA_W - SHIFT_4K;
    localparam int FN_W  = PA_W - SHIFT_4K;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int OFF2M = SHIFT_4K + EXTRA_2M;
    localparam int OFF1G = SHIFT_4K + EXTRA_1G;

    // entry storage
    logic [ENTRIES-1:0]            valid_q;
    logic [VPN_W-1:0]              vpn_q   [ENTRIES];
    logic [FN_W-1:0]               pfn_q   [ENTRIES];
    logic [TAG_W-1:0]              tag_q   [ENTRIES];
    pg_size_e                      size_q  [ENTRIES];
    logic [2:0]                    perm_q  [ENTRIES];
    logic [ENTRIES-1:0]            dirty_q;

    logic [ENTRIES-1:0]            hit_vec;
    logic                          any_hit;
    logic [IDX_W-1:0]              hit_idx;
    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [IDX_W-1:0]              victim;
    op_e                           op;
    logic                          touch;
    logic [IDX_W-1:0]              touch_idx;
    logic [VPN_W-1:0]              req_vpn;

    assign req_vpn = lk_vaddr[VA_W-1:SHIFT_4K];

    // parallel compare, one comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        xlat_entry_match #(
            .VPN_W (VPN_W),
            .TAG_W (TAG_W)
        ) cmp_i (
            .e_valid (valid_q[g]),
            .e_vpn   (vpn_q[g]),
            .e_tag   (tag_q[g]),
            .e_size  (size_q[g]),
            .req_vpn (req_vpn),
            .req_tag (lk_tag),
            .hit     (hit_vec[g])
        );
    end

    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // write-side operation decode
    always_comb begin
        if (inv_all)          op = OP_INV_ALL;
        else if (inv_tag_en)  op = OP_INV_TAG;
        else if (fill_en)     op = OP_FILL;
        else                  op = OP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                pfn_q[i]  <= '0;
                tag_q[i]  <= '0;
                size_q[i] <= PG_4K;
                perm_q[i] <= '0;
            end
        end else begin
            unique case (op)
                OP_INV_ALL: valid_q <= '0;
                OP_INV_TAG: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (tag_q[i] == inv_tag) valid_q[i] <= 1'b0;
                    end
                end
                OP_FILL: begin
                    valid_q[victim] <= 1'b1;
                    dirty_q[victim] <= fill_dirty;
                    vpn_q[victim]   <= fill_vpn;
                    pfn_q[victim]   <= fill_pfn;
                    tag_q[victim]   <= fill_tag;
                    size_q[victim]  <= pg_size_e'(fill_size);
                    perm_q[victim]  <= fill_perm;
                end
                OP_IDLE: ;
            endcase
        end
    end

    // recency
    xlat_victim_pick #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) pick_i (
        .valid  (valid_q),
        .age    (age_q),
        .victim (victim)
    );

    assign touch     = (op == OP_FILL) || (lk_valid && any_hit);
    assign touch_idx = (op == OP_FILL) ? victim : hit_idx;

    xlat_age_tracker #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) age_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .age_q     (age_q)
    );

    // lookup outputs
    logic            perm_ok;
    logic [2:0]      sel_perm;
    logic [FN_W-1:0] sel_pfn;
    pg_size_e        sel_size;
    logic [PA_W-1:0] base_pa;

    assign sel_perm = perm_q[hit_idx];
    assign sel_pfn  = pfn_q[hit_idx];
    assign sel_size = size_q[hit_idx];
    assign base_pa  = {sel_pfn, {SHIFT_4K{1'b0}}};

    always_comb begin
        unique case (acc_e'(lk_acc))
            ACC_READ:  perm_ok = sel_perm[PERM_R];
            ACC_WRITE: perm_ok = sel_perm[PERM_W];
            ACC_EXEC:  perm_ok = sel_perm[PERM_X];
            default:   perm_ok = 1'b0;
        endcase
    end

    always_comb begin
        lk_hit       = lk_valid && any_hit;
        lk_fault     = lk_hit && !perm_ok;
        lk_dirty_req = lk_hit && perm_ok && (acc_e'(lk_acc) == ACC_WRITE) && !dirty_q[hit_idx];
        lk_paddr     = '0;
        if (lk_hit) begin
            unique case (sel_size)
                PG_2M:   lk_paddr = {base_pa[PA_W-1:OFF2M], lk_vaddr[OFF2M-1:0]};
                PG_1G:   lk_paddr = {base_pa[PA_W-1:OFF1G], lk_vaddr[OFF1G-1:0]};
                default: lk_paddr = {sel_pfn, lk_vaddr[SHIFT_4K-1:0]};
            endcase
        end
    end

endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lk_valid,
    input  logic [11:0]                   lk_off,
    input  logic [1:0]                    lk_acc,
    input  logic                          lk_hit,
    input  logic [11:0]                   pa_off,
    input  logic                          lk_fault,
    input  logic                          lk_dirty_req,
    input  logic                          fill_en,
    input  logic                          inv_tag_en,
    input  logic                          inv_all,
    input  logic [ENTRIES-1:0]            valid_q,
    input  logic [ENTRIES-1:0][IDX_W-1:0] age_q
);

    localparam int SEEN_W = 1 << IDX_W;

    logic [SEEN_W-1:0] seen;

    always_comb begin
        seen = '0;
        for (int i = 0; i < ENTRIES; i++) seen[age_q[i]] = 1'b1;
    end

    p_hit_needs_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid);

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (pa_off == lk_off));

    p_fault_implies_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    p_dirty_req_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dirty_req |-> (lk_hit && !lk_fault && lk_acc == 2'd1));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));

    p_fill_occupies_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_all && !inv_tag_en) |=> (valid_q != '0));

    p_ages_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == ENTRIES);

endmodule

bind vtag_xlat_cache xlat_checker #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_off       (lk_vaddr[11:0]),
    .lk_acc       (lk_acc),
    .lk_hit       (lk_hit),
    .pa_off       (lk_paddr[11:0]),
    .lk_fault     (lk_fault),
    .lk_dirty_req (lk_dirty_req),
    .fill_en      (fill_en),
    .inv_tag_en   (inv_tag_en),
    .inv_all      (inv_all),
    .valid_q      (valid_q),
    .age_q        (age_q)
);

// File: tb/vtag_xlat_cache_tb_top.sv
module vtag_xlat_cache_tb_top;

    localparam int PA_W = 44;
    localparam int TAG_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [47:0]       lk_vaddr = '0;
    logic [TAG_W-1:0]  lk_tag = '0;
    logic [1:0]        lk_acc = '0;
    logic              lk_hit;
    logic [PA_W-1:0]   lk_paddr;
    logic              lk_fault;
    logic              lk_dirty_req;
    logic              fill_en = 1'b0;
    logic [35:0]       fill_vpn = '0;
    logic [TAG_W-1:0]  fill_tag = '0;
    logic [31:0]       fill_pfn = '0;
    logic [1:0]        fill_size = '0;
    logic [2:0]        fill_perm = '0;
    logic              fill_dirty = 1'b0;
    logic              inv_tag_en = 1'b0;
    logic [TAG_W-1:0]  inv_tag = '0;
    logic              inv_all = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vtag_xlat_cache dut_i (
        .clk (clk), .rst_n (rst_n),
        .lk_valid (lk_valid), .lk_vaddr (lk_vaddr), .lk_tag (lk_tag), .lk_acc (lk_acc),
        .lk_hit (lk_hit), .lk_paddr (lk_paddr), .lk_fault (lk_fault), .lk_dirty_req (lk_dirty_req),
        .fill_en (fill_en), .fill_vpn (fill_vpn), .fill_tag (fill_tag), .fill_pfn (fill_pfn),
        .fill_size (fill_size), .fill_perm (fill_perm), .fill_dirty (fill_dirty),
        .inv_tag_en (inv_tag_en), .inv_tag (inv_tag), .inv_all (inv_all)
    );

    // scoreboard: {hit, fault, dirty_req, paddr}
    logic [PA_W+2:0] exp_q[$];
    string           name_q[$];
    event            drive_ev;

    always begin
        @(drive_ev);
        #1;
        while (exp_q.size() > 0) begin
            logic [PA_W+2:0] e;
            logic [PA_W+2:0] a;
            string           n;
            e = exp_q.pop_front();
            n = name_q.pop_front();
            a = {lk_hit, lk_fault, lk_dirty_req, lk_paddr};
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s: actual hit=%0b fault=%0b dreq=%0b pa=%h expected hit=%0b fault=%0b dreq=%0b pa=%h",
                         n, a[PA_W+2], a[PA_W+1], a[PA_W], a[PA_W-1:0],
                         e[PA_W+2], e[PA_W+1], e[PA_W], e[PA_W-1:0]);
            end
        end
    end

    task automatic push_exp(input logic h, input logic f, input logic d,
                            input logic [PA_W-1:0] pa, input string n);
        exp_q.push_back({h, f, d, pa});
        name_q.push_back(n);
        -> drive_ev;
    endtask

    task automatic look(input logic [47:0] va, input logic [TAG_W-1:0] tg, input logic [1:0] acc,
                        input logic h, input logic f, input logic d,
                        input logic [PA_W-1:0] pa, input string n);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_tag = tg; lk_acc = acc;
        push_exp(h, f, d, pa, n);
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [35:0] vpn, input logic [TAG_W-1:0] tg, input logic [31:0] pfn,
                        input logic [1:0] sz, input logic [2:0] perm, input logic dty);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_tag = tg; fill_pfn = pfn;
        fill_size = sz; fill_perm = perm; fill_dirty = dty;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush_all();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    task automatic drop_tag(input logic [TAG_W-1:0] tg);
        @(negedge clk);
        inv_tag_en = 1'b1; inv_tag = tg;
        @(negedge clk);
        inv_tag_en = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: all entries invalid (R4)
        @(negedge clk);
        push_exp(1'b0, 1'b0, 1'b0, '0, "R4 outputs idle in reset");
        rst_n = 1'b1;
        look(48'h0000_1234_5ABC, 8'd5, 2'd0, 0, 0, 0, '0, "R4 miss after reset");

        // 4 KB entry, perms read+write, clean
        fill(36'h000012345, 8'd5, 32'h000ABCDE, 2'd0, 3'b011, 1'b0);
        look(48'h0000_1234_5ABC, 8'd5, 2'd0, 1, 0, 0, 44'h000ABCDEABC, "R1 R2 4K read hit");
        look(48'h0000_1234_5ABC, 8'd5, 2'd1, 1, 0, 1, 44'h000ABCDEABC, "R11 write to clean page");
        look(48'h0000_1234_5ABC, 8'd5, 2'd2, 1, 1, 0, 44'h000ABCDEABC, "R5 exec not permitted");
        look(48'h0000_1234_5ABC, 8'd5, 2'd3, 1, 1, 0, 44'h000ABCDEABC, "R5 code 3 faults");
        look(48'h0000_1234_5ABC, 8'd6, 2'd0, 0, 0, 0, '0, "R3 other tag misses");
        look(48'h0000_1234_6ABC, 8'd5, 2'd0, 0, 0, 0, '0, "R6 4K neighbour page misses");

        // 2 MB entry, perms read+exec, dirty
        fill(36'h000040600, 8'd5, 32'h00012200, 2'd1, 3'b101, 1'b1);
        look(48'h0000_407A_BCDE, 8'd5, 2'd0, 1, 0, 0, 44'h0000123ABCDE, "R2 R6 2M hit offset");
        look(48'h0000_407A_BCDE, 8'd5, 2'd1, 1, 1, 0, 44'h0000123ABCDE, "R5 R11 write fault on 2M");
        look(48'h0000_4080_0000, 8'd5, 2'd0, 0, 0, 0, '0, "R6 next 2M region misses");

        // 1 GB entry, all perms, dirty
        fill(36'h00C000000, 8'd5, 32'h00400000, 2'd2, 3'b111, 1'b1);
        look(48'h00C0_2345_6789, 8'd5, 2'd1, 1, 0, 0, 44'h00423456789, "R2 R6 R11 1G dirty write");
        look(48'h0080_2345_6789, 8'd5, 2'd0, 0, 0, 0, '0, "R6 other 1G misses");

        // tag 7 entry survives invalidate of tag 5
        fill(36'h000000007, 8'd7, 32'h00000077, 2'd0, 3'b111, 1'b0);
        drop_tag(8'd5);
        look(48'h0000_1234_5ABC, 8'd5, 2'd0, 0, 0, 0, '0, "R9 tag 5 4K removed");
        look(48'h00C0_2345_6789, 8'd5, 2'd0, 0, 0, 0, '0, "R9 tag 5 1G removed");
        look(48'h0000_0000_7123, 8'd7, 2'd2, 1, 0, 0, 44'h00000077123, "R9 tag 7 kept");

        // lookup in same cycle as invalidate sees old state
        @(negedge clk);
        inv_tag_en = 1'b1; inv_tag = 8'd7;
        lk_valid = 1'b1; lk_vaddr = 48'h0000_0000_7123; lk_tag = 8'd7; lk_acc = 2'd0;
        push_exp(1, 0, 0, 44'h00000077123, "R9 same-cycle lookup sees old");
        @(posedge clk);
        #1 inv_tag_en = 1'b0; lk_valid = 1'b0;
        look(48'h0000_0000_7123, 8'd7, 2'd0, 0, 0, 0, '0, "R9 gone after edge");

        // fill dropped when raised with an invalidate (R10)
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 36'h000000055; fill_tag = 8'd9; fill_pfn = 32'h55;
        fill_size = 2'd0; fill_perm = 3'b111; fill_dirty = 1'b0;
        inv_tag_en = 1'b1; inv_tag = 8'd4;
        @(negedge clk);
        fill_en = 1'b0; inv_tag_en = 1'b0;
        look(48'h0000_0005_5000, 8'd9, 2'd0, 0, 0, 0, '0, "R10 fill dropped under invalidate");

        // flush
        fill(36'h000000008, 8'd3, 32'h00000088, 2'd0, 3'b001, 1'b0);
        look(48'h0000_0000_8000, 8'd3, 2'd0, 1, 0, 0, 44'h00000088000, "R7 fill installs");
        flush_all();
        look(48'h0000_0000_8000, 8'd3, 2'd0, 0, 0, 0, '0, "R10 flush clears");

        // fill all entries; page 3 carries tag 2
        for (int i = 0; i < 8; i++)
            fill(36'(i), (i == 3) ? 8'd2 : 8'd1, 32'h100 + 32'(i), 2'd0, 3'b001, 1'b0);
        drop_tag(8'd2);
        fill(36'd9, 8'd1, 32'h109, 2'd0, 3'b001, 1'b0);
        for (int i = 0; i < 10; i++) begin
            if (i != 3 && i != 8)
                look({36'(i), 12'h010}, 8'd1, 2'd0, 1, 0, 0, {32'h100 + 32'(i), 12'h010},
                     "R7 freed slot reused, no eviction");
        end
        look({36'd0, 12'h010}, 8'd1, 2'd0, 1, 0, 0, {32'h100, 12'h010}, "R8 touch page 0");
        fill(36'd10, 8'd1, 32'h10A, 2'd0, 3'b001, 1'b0);
        look({36'd1, 12'h010}, 8'd1, 2'd0, 0, 0, 0, '0, "R8 LRU page 1 evicted");
        look({36'd0, 12'h010}, 8'd1, 2'd0, 1, 0, 0, {32'h100, 12'h010}, "R8 recent page 0 kept");
        look({36'd10, 12'h010}, 8'd1, 2'd0, 1, 0, 0, {32'h10A, 12'h010}, "R8 new page resident");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule